// File: doc/BRIEF.md
# Thread-and-Privilege-Qualified Event Counter

This block counts performance events for a core that runs two hardware threads. Every cycle it may see a thread-specific event from thread 0, a thread-specific event from thread 1, and a thread-independent event that belongs to neither thread. It also sees whether each thread is currently at OS or user privilege. Four qualification flags, one per thread and privilege pair, decide which occurrences add to a 40-bit count.

A thread-specific event is filtered only by the flags of the thread that raised it. A thread-independent event is counted once if either thread's current privilege matches an enabled flag of that thread. Software can load any value into the count at any time, and that load wins over counting in the same cycle. A sticky overflow flag records a carry out of the top bit.

The event pulses form a plain per-cycle sample with no handshake. The block accepts every cycle and never applies back-pressure, so an event pulse is counted or dropped in the cycle it is presented. All outputs are registered and change at the rising clock edge after the inputs that caused the change.

Top module: `evq_counter`

## Requirements
- R1: After reset the count is 0 and the overflow flag is 0.
- R2: A thread 0 specific event (`ev_t0`) adds one when `cfg_qual[3]` is 1 and `t0_in_os` is 1, or when `cfg_qual[2]` is 1 and `t0_in_os` is 0. `cfg_qual[1:0]` and `t1_in_os` have no effect on it.
- R3: A thread 1 specific event (`ev_t1`) adds one when `cfg_qual[1]` is 1 and `t1_in_os` is 1, or when `cfg_qual[0]` is 1 and `t1_in_os` is 0. `cfg_qual[3:2]` and `t0_in_os` have no effect on it.
- R4: When `ev_t0` and `ev_t1` both qualify in the same cycle, the count rises by 2 in that cycle.
- R5: A thread-independent event (`ev_ti`) adds exactly one when thread 0 matches its flags (as in R2) or thread 1 matches its flags (as in R3), and adds nothing otherwise. It adds to any thread-specific increments of the same cycle, so one cycle can add up to 3.
- R6: With `cfg_qual` = 0000 the count never moves, whatever events and privilege levels are presented.
- R7: With `cfg_qual` = 1111 every presented event is counted, whatever the privilege levels.
- R8: With `cfg_enable` = 0 the count does not move.
- R9: When `wr_en` is 1 the count takes `wr_data` at the next edge, and any increment in that cycle is discarded.
- R10: An increment that carries out of bit 39 wraps the count modulo 2^40 and sets `overflow`. The flag stays set until `clr_ovf` is 1; if a new carry and `clr_ovf` occur in the same cycle the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Counting enable |
| cfg_qual | input | 4 | Flags: [3] T0 OS, [2] T0 user, [1] T1 OS, [0] T1 user |
| t0_in_os | input | 1 | Thread 0 privilege: 1 = OS, 0 = user |
| t1_in_os | input | 1 | Thread 1 privilege: 1 = OS, 0 = user |
| ev_t0 | input | 1 | Thread-specific event raised by thread 0 this cycle |
| ev_t1 | input | 1 | Thread-specific event raised by thread 1 this cycle |
| ev_ti | input | 1 | Thread-independent event this cycle |
| wr_en | input | 1 | Load `wr_data` into the count |
| wr_data | input | 40 | Value to load |
| clr_ovf | input | 1 | Clear the overflow flag |
| count | output | 40 | Current count |
| overflow | output | 1 | Sticky carry-out flag |

## Verification
The qualification logic is driven with random flag settings, privilege levels and event mixes, which separates a design that filters a thread's event by the wrong thread's flags from one that does not, and exposes double counting of the thread-independent event when both threads match. Directed patterns cover the all-clear and all-set flag settings, single-flag settings that split OS from user on each thread, simultaneous events from both threads, and a load in the same cycle as qualified events. A count loaded just below the wrap point shows the carry, the sticky flag, and the priority of a new carry over a clear.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int unsigned NUM_THR = 2;
  localparam int unsigned QUAL_W  = 2 * NUM_THR;
  localparam int unsigned INC_W   = 2;

  typedef struct packed {
    logic os_en;
    logic usr_en;
  } thr_flags_t;

  function automatic thr_flags_t flags_of(input logic [QUAL_W-1:0] q, input int unsigned thr);
    thr_flags_t f;
    f.os_en  = q[2*(NUM_THR-1-thr)+1];
    f.usr_en = q[2*(NUM_THR-1-thr)];
    return f;
  endfunction
endpackage

// File: rtl/evq_qualify.sv
module evq_qualify
  import evq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [QUAL_W-1:0]    qual,
  input  logic [NUM_THR-1:0]   in_os,
  input  logic [NUM_THR-1:0]   ev_thr,
  input  logic                 ev_shared,
  output logic [INC_W-1:0]     inc
);
  logic [NUM_THR-1:0] thr_match;
  logic [NUM_THR-1:0] thr_hit;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    thr_flags_t fl;
    assign fl           = flags_of(qual, g);
    assign thr_match[g] = in_os[g] ? fl.os_en : fl.usr_en;
    assign thr_hit[g]   = ev_thr[g] & thr_match[g];
  end

  logic shared_hit;
  assign shared_hit = ev_shared & (|thr_match);

  always_comb begin
    inc = '0;
    if (enable) begin
      for (int i = 0; i < NUM_THR; i++) inc = inc + INC_W'(thr_hit[i]);
      inc = inc + INC_W'(shared_hit);
    end
  end

  // R6
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual == '0) |-> (inc == '0));
  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (inc == '0));
  // R5
  shared_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_thr == '0) |-> (inc <= INC_W'(1)));
  // R7
  all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (&qual)) |-> (inc == INC_W'($countones({ev_thr, ev_shared}))));
endmodule

// File: rtl/evq_accum.sv
module evq_accum
  import evq_pkg::*;
#(
  parameter int unsigned CNT_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  inc,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              clr_ovf,
  output logic [CNT_W-1:0]  count,
  output logic              overflow
);
  logic [CNT_W:0] sum;
  logic           carry;

  assign sum   = {1'b0, count} + {{(CNT_W+1-INC_W){1'b0}}, inc};
  assign carry = sum[CNT_W] & ~wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en) count <= wr_data;
      else       count <= sum[CNT_W-1:0];
      if (carry)        overflow <= 1'b1;
      else if (clr_ovf) overflow <= 1'b0;
    end
  end

  // R9
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)));
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr_ovf) |=> overflow);
  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> (count < CNT_W'(INC_W'(3))));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && inc == '0) |=> $stable(count));
endmodule

// File: rtl/evq_counter.sv
module evq_counter
  import evq_pkg::*;
#(
  parameter int unsigned CNT_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [3:0]        cfg_qual,
  input  logic              t0_in_os,
  input  logic              t1_in_os,
  input  logic              ev_t0,
  input  logic              ev_t1,
  input  logic              ev_ti,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              clr_ovf,
  output logic [CNT_W-1:0]  count,
  output logic              overflow
);
  logic [INC_W-1:0] inc;

  evq_qualify u_qualify (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .qual      (cfg_qual),
    .in_os     ({t1_in_os, t0_in_os}),
    .ev_thr    ({ev_t1, ev_t0}),
    .ev_shared (ev_ti),
    .inc       (inc)
  );

  evq_accum #(.CNT_W(CNT_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (inc),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .clr_ovf  (clr_ovf),
    .count    (count),
    .overflow (overflow)
  );

  // R4
  dual_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && ev_t0 && ev_t1 && !ev_ti && !wr_en
     && (t0_in_os ? cfg_qual[3] : cfg_qual[2])
     && (t1_in_os ? cfg_qual[1] : cfg_qual[0]))
    |=> (count == $past(count) + CNT_W'(2)));
endmodule

// File: tb/evq_counter_bench.sv
module evq_counter_bench;
  localparam int CW = 40;
  localparam time PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, t0_in_os = 0, t1_in_os = 0;
  logic [3:0] cfg_qual = 0;
  logic ev_t0 = 0, ev_t1 = 0, ev_ti = 0, wr_en = 0, clr_ovf = 0;
  logic [CW-1:0] wr_data = 0;
  logic [CW-1:0] count;
  logic overflow;

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] exp_cnt = 0;
  logic exp_ovf = 0;
  bit done = 0;

  evq_counter u_evq_counter (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic int calc_inc(logic en, logic [3:0] q, logic o0, logic o1,
                                  logic e0, logic e1, logic ei);
    logic m0, m1;
    int s;
    m0 = o0 ? q[3] : q[2];
    m1 = o1 ? q[1] : q[0];
    s = 0;
    if (en) s = int'(e0 & m0) + int'(e1 & m1) + int'(ei & (m0 | m1));
    return s;
  endfunction

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle, update model, check outputs after the edge
  task automatic cyc(string req, logic en, logic [3:0] q, logic o0, logic o1,
                     logic e0, logic e1, logic ei, logic we, logic [CW-1:0] wd, logic clr);
    logic [CW:0] s;
    int k;
    @(negedge clk);
    cfg_enable = en; cfg_qual = q; t0_in_os = o0; t1_in_os = o1;
    ev_t0 = e0; ev_t1 = e1; ev_ti = ei; wr_en = we; wr_data = wd; clr_ovf = clr;
    k = calc_inc(en, q, o0, o1, e0, e1, ei);
    @(posedge clk);
    #1;
    if (we) exp_cnt = wd;
    else begin
      s = {1'b0, exp_cnt} + (CW+1)'(k);
      exp_cnt = s[CW-1:0];
      if (s[CW]) exp_ovf = 1;
      else if (clr) exp_ovf = 0;
    end
    if (we && clr) exp_ovf = 0;
    check(req, count, exp_cnt);
    check(req, {{(CW-1){1'b0}}, overflow}, {{(CW-1){1'b0}}, exp_ovf});
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #(PERIOD*2);
    #1;
    // R1 reset state
    check("R1", count, '0);
    check("R1", {{(CW-1){1'b0}}, overflow}, '0);
    @(negedge clk); rst_n = 1;

    // R6 all flags clear
    for (int i = 0; i < 8; i++)
      cyc("R6", 1, 4'b0000, i[0], i[1], 1, 1, 1, 0, 0, 0);
    // R7 all flags set
    for (int i = 0; i < 4; i++)
      cyc("R7", 1, 4'b1111, i[0], i[1], 1, i[0], 1, 0, 0, 0);
    // R2 thread 0 user only; T1 flags ignored
    cyc("R2", 1, 4'b0100, 0, 1, 1, 0, 0, 0, 0, 0);
    cyc("R2", 1, 4'b0100, 1, 0, 1, 0, 0, 0, 0, 0);
    cyc("R2", 1, 4'b1011, 0, 1, 1, 0, 0, 0, 0, 0);
    // R3 thread 1 OS/user both
    cyc("R3", 1, 4'b0011, 1, 0, 0, 1, 0, 0, 0, 0);
    cyc("R3", 1, 4'b0011, 0, 1, 0, 1, 0, 0, 0, 0);
    cyc("R3", 1, 4'b1100, 1, 1, 0, 1, 0, 0, 0, 0);
    // R4 both threads
    cyc("R4", 1, 4'b1010, 1, 1, 1, 1, 0, 0, 0, 0);
    // R5 shared event counted once
    cyc("R5", 1, 4'b1010, 1, 1, 0, 0, 1, 0, 0, 0);
    cyc("R5", 1, 4'b1010, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R5", 1, 4'b0001, 1, 0, 1, 0, 1, 0, 0, 0);
    // R8 disabled
    cyc("R8", 0, 4'b1111, 1, 0, 1, 1, 1, 0, 0, 0);
    // R9 write beats increment
    cyc("R9", 1, 4'b1111, 1, 1, 1, 1, 1, 1, 40'h12_3456_789A, 0);
    // R10 wrap
    cyc("R10", 1, 4'b1111, 0, 0, 0, 0, 0, 1, {CW{1'b1}} - 1, 0);
    cyc("R10", 1, 4'b1111, 0, 0, 1, 1, 1, 0, 0, 0);
    cyc("R10", 1, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10", 1, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R10", 1, 4'b1111, 0, 0, 0, 0, 0, 1, {CW{1'b1}}, 0);
    cyc("R10", 1, 4'b1111, 0, 0, 1, 0, 0, 0, 0, 1);

    // random mix R2 R3 R4 R5 R9
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R2/R3/R5 random", r[0] | r[1], r[5:2], r[6], r[7], r[8], r[9], r[10],
          (r[15:11] == 0), {8'h0, $urandom}, r[16] & r[17]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule